// File: doc/BRIEF.md
# Three-Track Stripe Bit Buffer with Strobe Readout

This block gathers decoded bits from three card tracks into a fixed on-chip store and hands them to a host controller over a single serial output, `data_o`. Each track has a bit stream input with valid/ready flow control. A track keeps nothing until its first one-bit arrives. From that one-bit on it stores bits in arrival order, up to `TRACK_BITS` of them.

When the swipe ends, `card_end` is pulsed. If any track holds data, `data_o` falls and stays low as a ready flag. The host then gives two handshake pulses on the active-low `strobe_n`. After the handshake, every further low pulse presents one stored bit on `data_o`, which goes low for a one-bit and high for a zero-bit. The read pointer steps forward when `strobe_n` rises. Readout runs forward through tracks A, B and C, then runs back through C, B and A. It repeats for `ROUND_TRIPS` round trips, after which the block goes quiet until reset.

Back-pressure rules for the inputs: `in_ready` is high for every track only while the block is capturing. A bit transfers on a cycle in which both `in_valid` and `in_ready` are high for that track. A track that is full keeps `in_ready` high and discards the extra bits. The source never stalls during a swipe.

Top module: `stripe_buffer`

## Requirements
- R1: After reset, `phase_o` is 0 (capture), `data_o` is 1 and `in_ready` is all ones.
- R2: On each track, a zero-bit offered before that track's first accepted one-bit is dropped. Storage begins with that one-bit.
- R3: Each track stores at most `TRACK_BITS` bits. Bits offered after that are discarded.
- R4: While `phase_o` is 0, `data_o` is high and `in_ready` is all ones. In every other phase `in_ready` is all zeros, and bits offered then are not stored.
- R5: If `card_end` arrives while at least one track holds data, `phase_o` becomes 1 and `data_o` goes low. If `card_end` arrives while no track holds data, the block stays in phase 0 with `data_o` high.
- R6: In phase 1, `data_o` stays low through the first complete `strobe_n` pulse. The rising edge of the second pulse moves the block to phase 2.
- R7: In phase 2, while `strobe_n` is low, `data_o` is the inverse of the bit at the read pointer (low means 1). Each rising edge of `strobe_n` advances the pointer.
- R8: The forward pass reads track A offsets 0 to TRACK_BITS-1, then track B, then track C. The backward pass reads the same positions in exactly the reverse order, starting again at the last position of C. One round trip is therefore 2*3*TRACK_BITS pulses.
- R9: A position beyond the number of bits a track received reads as a zero-bit, so `data_o` is high there.
- R10: When the last pulse of round trip `ROUND_TRIPS` rises, `phase_o` becomes 3 and `data_o` goes high. From then until reset, `strobe_n` pulses change neither output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | NUM_TRACKS | Per-track bit valid (bit 0 = track A) |
| in_bit | input | NUM_TRACKS | Per-track bit value |
| in_ready | output | NUM_TRACKS | Per-track ready, high only while capturing |
| card_end | input | 1 | One-cycle pulse marking the end of a swipe |
| strobe_n | input | 1 | Asynchronous active-low readout strobe from the host |
| data_o | output | 1 | Ready flag, then serial readout, active low for a one-bit |
| phase_o | output | 2 | Test status: 0 capture, 1 handshake, 2 readout, 3 exhausted |

## Verification
The embedded assertions hold on every cycle. They bound each track's fill count. They check that a fill count never moves while capture is closed, and that a leading zero-bit never starts a track. They bound the pointer's track index and the round-trip count. They also check that the exhausted phase is sticky and that `data_o` holds steady between strobe steps during readout. Other behaviour shows only in the bench's scenarios: the exact serpentine order, including the repeated end points, the inverted bit polarity, the zero fill of short tracks, the two-pulse handshake, and discarding of overflow and late bits.

// File: rtl/stripe_pkg.sv
package stripe_pkg;
  typedef enum logic [1:0] {
    PH_CAPTURE = 2'd0,
    PH_HANDSHK = 2'd1,
    PH_READOUT = 2'd2,
    PH_SPENT   = 2'd3
  } phase_t;
endpackage

// File: rtl/stripe_strobe_sync.sv
module stripe_strobe_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe_n,
  output logic rise_o
);
  logic s1, s2, s3;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b1;
      s2 <= 1'b1;
      s3 <= 1'b1;
    end else begin
      s1 <= strobe_n;
      s2 <= s1;
      s3 <= s2;
    end
  end

  assign rise_o = s2 & ~s3;
endmodule

// File: rtl/stripe_track.sv
module stripe_track #(
  parameter int TRACK_BITS = 608
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          en,
  input  logic                          valid,
  input  logic                          bit_i,
  input  logic [$clog2(TRACK_BITS)-1:0] rd_off,
  output logic                          has_data,
  output logic                          rd_bit
);
  localparam int OW = $clog2(TRACK_BITS);
  localparam int CW = $clog2(TRACK_BITS + 1);

  logic [TRACK_BITS-1:0] mem;
  logic [CW-1:0]         fill;
  logic                  wr;

  assign wr = en && valid && (fill != '0 || bit_i) && (fill < CW'(TRACK_BITS));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fill <= '0;
    else if (wr) fill <= fill + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (wr) mem[fill[OW-1:0]] <= bit_i;
  end

  assign has_data = (fill != '0);
  assign rd_bit   = (CW'(rd_off) < fill) ? mem[rd_off] : 1'b0;

  // R3
  fill_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= CW'(TRACK_BITS));
  // R4
  closed_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(fill));
  // R2
  lead_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fill == '0 && !bit_i) |=> fill == '0);
endmodule

// File: rtl/stripe_read_seq.sv
module stripe_read_seq #(
  parameter int NUM_TRACKS  = 3,
  parameter int TRACK_BITS  = 608,
  parameter int ROUND_TRIPS = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          start,
  input  logic                          step,
  output logic [$clog2(NUM_TRACKS)-1:0] trk_o,
  output logic [$clog2(TRACK_BITS)-1:0] off_o,
  output logic                          done_o
);
  localparam int KW = $clog2(NUM_TRACKS);
  localparam int OW = $clog2(TRACK_BITS);
  localparam int TW = $clog2(ROUND_TRIPS + 1);

  logic          backward;
  logic [TW-1:0] trips;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trk_o <= '0; off_o <= '0; backward <= 1'b0; trips <= '0; done_o <= 1'b0;
    end else if (start) begin
      trk_o <= '0; off_o <= '0; backward <= 1'b0; trips <= '0; done_o <= 1'b0;
    end else if (step && !done_o) begin
      if (!backward) begin
        if (off_o == OW'(TRACK_BITS - 1)) begin
          if (trk_o == KW'(NUM_TRACKS - 1)) backward <= 1'b1;
          else begin
            trk_o <= trk_o + 1'b1;
            off_o <= '0;
          end
        end else off_o <= off_o + 1'b1;
      end else begin
        if (off_o == '0) begin
          if (trk_o == '0) begin
            backward <= 1'b0;
            trips    <= trips + 1'b1;
            if (trips + 1'b1 == TW'(ROUND_TRIPS)) done_o <= 1'b1;
          end else begin
            trk_o <= trk_o - 1'b1;
            off_o <= OW'(TRACK_BITS - 1);
          end
        end else off_o <= off_o - 1'b1;
      end
    end
  end

  // R8
  trk_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trk_o < KW'(NUM_TRACKS));
  // R10
  trip_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trips <= TW'(ROUND_TRIPS));
endmodule

// File: rtl/stripe_buffer.sv
module stripe_buffer #(
  parameter int NUM_TRACKS  = 3,
  parameter int TRACK_BITS  = 608,
  parameter int ROUND_TRIPS = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_TRACKS-1:0] in_valid,
  input  logic [NUM_TRACKS-1:0] in_bit,
  output logic [NUM_TRACKS-1:0] in_ready,
  input  logic                  card_end,
  input  logic                  strobe_n,
  output logic                  data_o,
  output logic [1:0]            phase_o
);
  import stripe_pkg::*;

  localparam int KW = $clog2(NUM_TRACKS);
  localparam int OW = $clog2(TRACK_BITS);

  phase_t                phase;
  logic                  hs_seen;
  logic                  rise, start, step, seq_done;
  logic [KW-1:0]         rd_trk;
  logic [OW-1:0]         rd_off;
  logic [NUM_TRACKS-1:0] has_data, trk_bit;
  logic                  cur_bit, capturing;

  assign capturing = (phase == PH_CAPTURE);
  assign in_ready  = {NUM_TRACKS{capturing}};

  stripe_strobe_sync u_sync (
    .clk(clk), .rst_n(rst_n), .strobe_n(strobe_n), .rise_o(rise)
  );

  for (genvar t = 0; t < NUM_TRACKS; t++) begin : g_trk
    stripe_track #(.TRACK_BITS(TRACK_BITS)) u_trk (
      .clk(clk), .rst_n(rst_n), .en(capturing),
      .valid(in_valid[t]), .bit_i(in_bit[t]), .rd_off(rd_off),
      .has_data(has_data[t]), .rd_bit(trk_bit[t])
    );
  end

  assign start = (phase == PH_HANDSHK) && rise && hs_seen;
  assign step  = (phase == PH_READOUT) && rise;

  stripe_read_seq #(
    .NUM_TRACKS(NUM_TRACKS), .TRACK_BITS(TRACK_BITS), .ROUND_TRIPS(ROUND_TRIPS)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .step(step),
    .trk_o(rd_trk), .off_o(rd_off), .done_o(seq_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= PH_CAPTURE;
      hs_seen <= 1'b0;
    end else begin
      unique case (phase)
        PH_CAPTURE: if (card_end && |has_data) begin
          phase   <= PH_HANDSHK;
          hs_seen <= 1'b0;
        end
        PH_HANDSHK: if (rise) begin
          if (hs_seen) phase <= PH_READOUT;
          hs_seen <= 1'b1;
        end
        PH_READOUT: if (seq_done) phase <= PH_SPENT;
        PH_SPENT:   phase <= PH_SPENT;
        default:    phase <= PH_CAPTURE;
      endcase
    end
  end

  assign cur_bit = trk_bit[rd_trk];

  always_comb begin
    unique case (phase)
      PH_HANDSHK: data_o = 1'b0;
      PH_READOUT: data_o = seq_done ? 1'b1 : ~cur_bit;
      default:    data_o = 1'b1;
    endcase
  end

  assign phase_o = phase;

  // R10
  spent_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    phase == PH_SPENT |=> phase == PH_SPENT);
  // R7
  readout_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_READOUT && !step && !seq_done) |=> $stable(data_o));
  // R6
  handshake_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
    phase == PH_HANDSHK |=> (phase == PH_HANDSHK || phase == PH_READOUT));
endmodule

// File: tb/tb_stripe_buffer.sv
module tb_stripe_buffer;
  localparam int NT = 3;
  localparam int TB = 4;
  localparam int RT = 4;
  localparam int N  = NT * TB;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NT-1:0] in_valid = '0, in_bit = '0, in_ready;
  logic card_end = 1'b0, strobe_n = 1'b1, data_o;
  logic [1:0] phase_o;

  int total = 0, bad = 0;
  bit finished = 0;
  bit exp_bits [NT][TB];

  always #5 clk = ~clk;

  stripe_buffer #(.NUM_TRACKS(NT), .TRACK_BITS(TB), .ROUND_TRIPS(RT)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_bit(in_bit),
    .in_ready(in_ready), .card_end(card_end), .strobe_n(strobe_n),
    .data_o(data_o), .phase_o(phase_o)
  );

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic send(int t, bit b);
    @(negedge clk);
    in_valid[t] = 1'b1; in_bit[t] = b;
    @(negedge clk);
    in_valid[t] = 1'b0; in_bit[t] = 1'b0;
  endtask

  task automatic end_card();
    @(negedge clk); card_end = 1'b1;
    @(negedge clk); card_end = 1'b0;
  endtask

  task automatic pulse(output bit sampled);
    @(negedge clk); strobe_n = 1'b0;
    repeat (5) @(negedge clk);
    sampled = data_o;
    strobe_n = 1'b1;
    repeat (5) @(negedge clk);
  endtask

  task automatic t_reset_state();
    do_reset();
    check("R1 phase", phase_o, 0);
    check("R1 data", data_o, 1);
    check("R1 ready", in_ready, 7);
  endtask

  task automatic t_no_data_end();
    do_reset();
    send(0, 0); send(1, 0); send(2, 0);
    end_card();
    check("R5 empty end phase", phase_o, 0);
    check("R5 empty end data", data_o, 1);
    check("R2 zeros still ready", in_ready, 7);
  endtask

  task automatic t_full_readout();
    bit s;
    do_reset();
    // track A: leading zeros dropped, overflow beyond TB dropped
    send(0, 0); send(0, 0); send(0, 1); send(0, 0); send(0, 1);
    send(0, 1); send(0, 0); send(0, 1); send(0, 1);
    // track B: short track
    send(1, 0); send(1, 1); send(1, 1);
    // track C: exactly full
    send(2, 1); send(2, 0); send(2, 0); send(2, 1);
    exp_bits[0] = '{1, 0, 1, 1};
    exp_bits[1] = '{1, 1, 0, 0};
    exp_bits[2] = '{1, 0, 0, 1};
    check("R4 capture data high", data_o, 1);
    end_card();
    check("R5 ready flag phase", phase_o, 1);
    check("R5 ready flag data", data_o, 0);
    check("R4 ready dropped", in_ready, 0);
    send(1, 1); send(1, 1); // late bits, must not be stored (R4)
    pulse(s);
    check("R6 first pulse data low", s, 0);
    check("R6 still handshake", phase_o, 1);
    pulse(s);
    check("R6 second pulse data low", s, 0);
    check("R6 readout phase", phase_o, 2);
    for (int r = 0; r < RT; r++) begin
      for (int k = 0; k < 2 * N; k++) begin
        int p = (k < N) ? k : (2 * N - 1 - k);
        pulse(s);
        // R7 polarity, R8 order, R9 zero fill, R2/R3/R4 stored contents
        check($sformatf("R8 R7 trip%0d step%0d", r, k), s,
              exp_bits[p / TB][p % TB] ? 0 : 1);
      end
    end
    repeat (2) @(negedge clk);
    check("R10 spent phase", phase_o, 3);
    check("R10 spent data", data_o, 1);
    pulse(s);
    check("R10 strobe ignored data", s, 1);
    check("R10 strobe ignored phase", phase_o, 3);
  endtask

  initial begin
    t_reset_state();
    t_no_data_end();
    t_full_readout();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule